// File: doc/BRIEF.md
# Eight-Channel Input Glitch Filter

This block sits between eight raw digital input levels (the outputs of analog threshold comparators) and the register that holds the input states. It runs on a slow free-running oscillator clock. A shared divider turns that clock into a filter tick, once every 8 or once every 64 clock cycles, chosen by a static select pin. Each channel passes a new level to its output only after the raw level has held steady across three tick edges. Short spikes of either polarity are therefore removed, and real level changes arrive with a bounded delay.

The filtered outputs are plain registers with no further staging. Downstream parity logic and indicator drivers see every change in the same cycle it happens. A power-on reset clears the divider, the synchronisers and every channel. The reset is applied asynchronously and released in step with the clock.

Top module: `chan_glitch_filter`

## Requirements
- R1: The eight channels are independent. Changing one raw input never alters the filtered output of any other channel, and all channels share one divided tick.
- R2: With `div_sel` = 0 the tick period is 8 clock cycles. With `div_sel` = 1 it is 64 clock cycles. The filter delays of R3 and R4 scale with this period D.
- R3: A raw pulse that lasts at most 2·D+1 clock cycles never appears at the output. A raw pulse that lasts at least 3·D+1 clock cycles always appears at the output.
- R4: A raw input is driven just before clock edge 1 and then held. The output takes the new level at clock edge n, where n lies between 2·D+4 and 3·D+3. This delay covers two synchroniser flops, one capture cycle and three tick edges, so it is 2 to 3 tick periods.
- R5: Rising and falling changes are filtered in the same way. Low-going pulses obey R3 and falling steps obey R4 exactly as the opposite polarity does.
- R6: If the raw level returns to its old value for even one clock cycle before it has been validated, that channel's count restarts. The delay measured from the final change again obeys R4.
- R7: While `rst_n` is low, every output is 0, and asserting `rst_n` clears the outputs without waiting for a clock edge. After release, every output stays 0 until a high level has been validated under R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| div_sel | input | 1 | Tick divider select: 0 divides by 8, 1 divides by 64 |
| raw_in | input | 8 | Unfiltered input levels, asynchronous to clk |
| filt_out | output | 8 | Validated input levels, one per channel |

## Verification
A bad divider count or a stuck counter inside one channel shows up as a shift in the step delay. The edge on which a channel's output flips moves outside the window of 2·D+4 to 3·D+3 cycles, so it is caught within one filter delay of the stimulus. A channel that fails to restart or miscounts tick edges lets a pulse of 2·D+1 cycles through, or drops one of 3·D+1 cycles. These errors are visible at the port within about 3·D cycles of the pulse ending. Crosstalk between channels, or a reset that does not clear some bit, shows directly as a wrong bit in the 8-bit output vector.

// File: rtl/flt_pkg.sv
package flt_pkg;
  localparam int unsigned FLT_NCH       = 8;
  localparam int unsigned FLT_CONFIRM   = 3;
  localparam int unsigned FLT_LO_LOG    = 3;
  localparam int unsigned FLT_HI_LOG    = 6;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/flt_rst_sync.sv
module flt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/flt_sync2.sv
module flt_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/flt_tick_gen.sv
module flt_tick_gen #(
  parameter int unsigned LO_LOG = 3,
  parameter int unsigned HI_LOG = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_sel_i,
  output logic tick_o
);
  logic [HI_LOG-1:0] cnt_q;
  logic [HI_LOG-1:0] cnt_d;
  logic              wrap_lo;
  logic              wrap_hi;

  generate
    if (LO_LOG >= HI_LOG) begin : g_bad_cfg
      initial $display("flt_tick_gen: LO_LOG must be below HI_LOG");
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wrap_lo = &cnt_q[LO_LOG-1:0];
  assign wrap_hi = &cnt_q;
  assign tick_o  = div_sel_i ? wrap_hi : wrap_lo;
endmodule

// File: rtl/flt_chan.sv
module flt_chan #(
  parameter int unsigned CONFIRM = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic lvl_i,
  output logic out_o
);
  localparam int unsigned CW = flt_pkg::cnt_width(CONFIRM);
  localparam logic [CW-1:0] LAST = CW'(CONFIRM - 1);

  logic          cand_q, cand_d;
  logic          out_q,  out_d;
  logic [CW-1:0] cnt_q,  cnt_d;

  always_comb begin
    cand_d = cand_q;
    out_d  = out_q;
    cnt_d  = cnt_q;
    if (lvl_i != cand_q) begin
      cand_d = lvl_i;
      cnt_d  = '0;
    end else if (cand_q == out_q) begin
      cnt_d  = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        out_d = cand_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cand_q <= cand_d;
      out_q  <= out_d;
      cnt_q  <= cnt_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/chan_glitch_filter.sv
module chan_glitch_filter #(
  parameter int unsigned NCH     = flt_pkg::FLT_NCH,
  parameter int unsigned CONFIRM = flt_pkg::FLT_CONFIRM,
  parameter int unsigned LO_LOG  = flt_pkg::FLT_LO_LOG,
  parameter int unsigned HI_LOG  = flt_pkg::FLT_HI_LOG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           div_sel,
  input  logic [NCH-1:0] raw_in,
  output logic [NCH-1:0] filt_out
);
  logic           rst_sn;
  logic           tick_w;
  logic [NCH-1:0] sync_w;

  flt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  flt_sync2 #(.W(NCH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sn),
    .async_i (raw_in),
    .sync_o  (sync_w)
  );

  flt_tick_gen #(.LO_LOG(LO_LOG), .HI_LOG(HI_LOG)) u_tick (
    .clk       (clk),
    .rst_n     (rst_sn),
    .div_sel_i (div_sel),
    .tick_o    (tick_w)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      flt_chan #(.CONFIRM(CONFIRM)) u_ch (
        .clk    (clk),
        .rst_n  (rst_sn),
        .tick_i (tick_w),
        .lvl_i  (sync_w[c]),
        .out_o  (filt_out[c])
      );
    end
  endgenerate
endmodule

// File: rtl/flt_chk.sv
module flt_chk #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned LO_LOG = 3,
  parameter int unsigned HI_LOG = 6
) (
  input logic           clk,
  input logic           rst_sn,
  input logic           div_sel,
  input logic           tick,
  input logic [NCH-1:0] sync_lvl,
  input logic [NCH-1:0] filt_out
);
  localparam logic [HI_LOG:0] GAP_LO = (HI_LOG+1)'((1 << LO_LOG) - 1);
  localparam logic [HI_LOG:0] GAP_HI = (HI_LOG+1)'((1 << HI_LOG) - 1);

  logic [HI_LOG:0] gap_q;
  logic            sel_prev_q;
  logic            moved_q;
  logic            moved_now;

  assign moved_now = moved_q | (div_sel != sel_prev_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gap_q      <= '0;
      sel_prev_q <= div_sel;
      moved_q    <= 1'b0;
    end else begin
      sel_prev_q <= div_sel;
      if (tick) begin
        gap_q   <= '0;
        moved_q <= 1'b0;
      end else begin
        gap_q   <= gap_q + 1'b1;
        moved_q <= moved_now;
      end
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && !moved_now) |-> (gap_q == (div_sel ? GAP_HI : GAP_LO))); // R2

  AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_sn)
    !tick |=> $stable(filt_out)); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_sn |-> (filt_out == '0)); // R7

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      AST_RISE_FROM_STEADY: assert property (@(posedge clk) disable iff (!rst_sn)
        $rose(filt_out[c]) |-> $past(sync_lvl[c])); // R3
      AST_FALL_FROM_STEADY: assert property (@(posedge clk) disable iff (!rst_sn)
        $fell(filt_out[c]) |-> !$past(sync_lvl[c])); // R5
    end
  endgenerate
endmodule

bind chan_glitch_filter flt_chk #(.NCH(NCH), .LO_LOG(LO_LOG), .HI_LOG(HI_LOG)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .div_sel  (div_sel),
  .tick     (tick_w),
  .sync_lvl (sync_w),
  .filt_out (filt_out)
);

// File: tb/sim_chan_glitch_filter.sv
`timescale 1ns/1ps
module sim_chan_glitch_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_sel;
  logic [7:0] raw;
  logic [7:0] filt_out;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  chan_glitch_filter u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_sel  (div_sel),
    .raw_in   (raw),
    .filt_out (filt_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int ch, input bit lvl, output int n);
    @(negedge clk);
    raw[ch] = lvl;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (filt_out[ch] != lvl && n < 1000);
  endtask

  task automatic chk_delay(input int n, input int d, input string req);
    chk(n >= 2*d+4 && n <= 3*d+3, req, "step delay", n, 2*d+4);
  endtask

  task automatic pulse(input int ch, input bit lvl, input int len,
                       input int d, input string req);
    bit seen = 1'b0;
    @(negedge clk);
    raw[ch] = lvl;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (filt_out[ch] == lvl) seen = 1'b1;
    end
    raw[ch] = ~lvl;
    for (int i = 0; i < 3*d+10; i++) begin
      @(negedge clk);
      if (filt_out[ch] == lvl) seen = 1'b1;
    end
    repeat (3*d+10) @(negedge clk);
    if (len <= 2*d+1) chk(!seen, req, "short pulse leaked", seen, 0);
    if (len >= 3*d+1) chk(seen, req, "long pulse lost", seen, 1);
    chk(filt_out[ch] == ~lvl, req, "level after pulse", filt_out[ch], ~lvl);
  endtask

  initial begin
    int n;
    logic [7:0] exp_v;
    rst_n = 1'b0; div_sel = 1'b0; raw = 8'hFF;
    repeat (5) @(negedge clk);
    chk(filt_out == 8'h00, "R7", "out in reset", filt_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(filt_out == 8'h00, "R7", "out just after release", filt_out, 0);
    repeat (40) @(negedge clk);
    chk(filt_out == 8'hFF, "R7", "out after validation", filt_out, 8'hFF);
    raw = 8'h00;
    repeat (40) @(negedge clk);
    chk(filt_out == 8'h00, "R5", "all fall", filt_out, 0);

    // R4 / R1 / R5: per-channel steps with D = 8
    exp_v = 8'h00;
    for (int ch = 0; ch < 8; ch++) begin
      step(ch, 1'b1, n);
      chk_delay(n, 8, "R4");
      exp_v[ch] = 1'b1;
      chk(filt_out == exp_v, "R1", "vector after rise", filt_out, exp_v);
    end
    for (int ch = 0; ch < 8; ch++) begin
      step(ch, 1'b0, n);
      chk_delay(n, 8, "R5");
      exp_v[ch] = 1'b0;
      chk(filt_out == exp_v, "R1", "vector after fall", filt_out, exp_v);
    end

    // R3 high pulses, R5 low pulses, D = 8
    for (int len = 1; len <= 27; len++) pulse(2, 1'b1, len, 8, "R3");
    raw[2] = 1'b1;
    repeat (40) @(negedge clk);
    for (int len = 1; len <= 27; len++) pulse(2, 1'b0, len, 8, "R5");
    chk(filt_out == 8'h04, "R1", "others untouched by pulses", filt_out, 8'h04);
    raw[2] = 1'b0;
    repeat (40) @(negedge clk);

    // R6 restart on toggle-back, D = 8
    @(negedge clk); raw[6] = 1'b1;
    repeat (16) @(negedge clk);
    raw[6] = 1'b0;
    chk(filt_out[6] == 1'b0, "R6", "no early accept", filt_out[6], 0);
    step(6, 1'b1, n);
    chk_delay(n, 8, "R6");

    // R2: divide by 64
    div_sel = 1'b1;
    repeat (70) @(negedge clk);
    step(4, 1'b1, n);
    chk_delay(n, 64, "R2");
    step(4, 1'b0, n);
    chk_delay(n, 64, "R2");
    pulse(4, 1'b1, 129, 64, "R2");
    pulse(4, 1'b1, 193, 64, "R2");
    raw[4] = 1'b1;
    repeat (210) @(negedge clk);
    pulse(4, 1'b0, 129, 64, "R5");
    pulse(4, 1'b0, 193, 64, "R5");
    @(negedge clk); raw[1] = 1'b1;
    repeat (128) @(negedge clk);
    raw[1] = 1'b0;
    step(1, 1'b1, n);
    chk_delay(n, 64, "R6");

    // R7: asynchronous clear mid-run
    raw = 8'hFF;
    repeat (210) @(negedge clk);
    chk(filt_out == 8'hFF, "R7", "all high before reset", filt_out, 8'hFF);
    @(negedge clk); #1 rst_n = 1'b0;
    #1 chk(filt_out == 8'h00, "R7", "async clear", filt_out, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(filt_out == 8'h00, "R7", "zero until revalidated", filt_out, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule